// File: doc/BRIEF.md
# Programmable Edge/Level Interrupt Request Latch

This block captures a bank of interrupt input lines into a request register, one bit per line. Each line is set to edge-triggered or level-triggered operation by a trigger-select register. In edge mode a line latches a request when its input goes from low to high, and the request stays set until that line is acknowledged. In level mode the request bit simply follows the input. The block keeps a one-cycle history of each input so that it can detect edges. All inputs are taken as synchronous to the block clock.

The trigger-select register can be written and read back. Only the bits allowed by a fixed per-instance capability mask can be set, and the other bits always read as zero, which leaves those lines in edge mode. An acknowledge strobe carries a line number. It clears the latched request of that line if the line is in edge mode and has no effect on a level-mode line. An initialization strobe clears all requests and all edge history but keeps the trigger selection. Priority resolution and command decoding belong to the surrounding logic.

Top module: `irq_req_latch`

## Requirements
- R1: For a level-mode line (trigger-select bit = 1), the request bit one cycle after a clock edge equals the input level sampled at that edge. This holds both high and low, and an acknowledge to that line has no effect.
- R2: For an edge-mode line (trigger-select bit = 0), the request bit is set one cycle after an edge at which the input is 1 and the previous sampled input of that line was 0.
- R3: For an edge-mode line, a falling input does not clear the latched request. An input held high sets the request only once, so it does not set it again after an acknowledge.
- R4: An acknowledge of line k (ack_i = 1, ack_line_i = k) clears request bit k on the next edge, but only if line k is in edge mode. If a new rising edge on that line arrives in the same cycle, the request stays set.
- R5: A write to the trigger-select register stores wdata AND WR_MASK, visible on trig_rdata_o one cycle later. Bits outside WR_MASK read 0.
- R6: While rst_ni is low, the trigger-select register, the request register and the edge history are all zero, so every line is in edge mode.
- R7: The initialization strobe clears the request register and the edge history on the next edge and leaves the trigger-select register unchanged. An edge-mode input that is still high afterwards latches again one cycle later.
- R8: The edge history is sampled every clock, so a high pulse of one clock cycle on an edge-mode line latches a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | NUM_LINES | Raw interrupt input lines, synchronous to clk_i |
| init_clr_i | input | 1 | Initialization strobe: clears requests and edge history |
| trig_we_i | input | 1 | Trigger-select write enable |
| trig_wdata_i | input | NUM_LINES | Trigger-select write data (1 = level, 0 = edge) |
| trig_rdata_o | output | NUM_LINES | Trigger-select read-back |
| ack_i | input | 1 | Acknowledge strobe |
| ack_line_i | input | IDX_W | Line number being acknowledged |
| req_o | output | NUM_LINES | Request register |

## Verification
The bench builds the block with eight lines and a capability mask of 0xF3. This leaves lines 2 and 3 fixed in edge mode while the other lines can be switched to level mode. With that mask, a single written pattern puts edge and level lines side by side in the same cycle. It also shows that masked bits read back as zero, that an acknowledge clears a fixed-edge line and is ignored by a level line, and that an acknowledge meeting a fresh rising edge on the same line leaves the request set.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/irq_trig_reg.sv
module irq_trig_reg #(
  parameter int unsigned        NUM_LINES = 8,
  parameter logic [NUM_LINES-1:0] WR_MASK = '1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [NUM_LINES-1:0] wdata_i,
  output logic [NUM_LINES-1:0] mode_o
);
  logic [NUM_LINES-1:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q <= '0;
    else if (we_i) mode_q <= wdata_i & WR_MASK;
  end

  assign mode_o = mode_q;

  AST_TRIG_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mode_o == ($past(wdata_i) & WR_MASK))); // R5
  AST_TRIG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mode_o)); // R5
endmodule

// File: rtl/irq_ack_decode.sv
module irq_ack_decode #(
  parameter int unsigned NUM_LINES = 8,
  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ack_i,
  input  logic [IDX_W-1:0]     ack_line_i,
  output logic [NUM_LINES-1:0] ack_vec_o
);
  always_comb begin
    ack_vec_o = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (ack_i && (ack_line_i == IDX_W'(i))) ack_vec_o[i] = 1'b1;
    end
  end

  AST_ACK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_vec_o)); // R4
  AST_ACK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |-> (ack_vec_o == '0)); // R4
endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
  import irq_latch_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  trig_mode_e mode_i,
  input  logic       line_i,
  input  logic       ack_i,
  input  logic       init_i,
  output logic       req_o
);
  logic req_q, hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      hist_q <= 1'b0;
    end else if (init_i) begin
      req_q  <= 1'b0;
      hist_q <= 1'b0;
    end else begin
      hist_q <= line_i;
      if (mode_i == TRIG_LEVEL) begin
        req_q <= line_i;
      end else if (line_i && !hist_q) begin
        req_q <= 1'b1;  // fresh edge wins over a same-cycle ack
      end else if (ack_i) begin
        req_q <= 1'b0;
      end
    end
  end

  assign req_o = req_q;

  AST_LEVEL_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TRIG_LEVEL && !init_i) |=> (req_o == $past(line_i))); // R1
  AST_EDGE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && mode_i == TRIG_EDGE && !init_i && line_i && !$past(line_i))
      |=> req_o); // R2
  AST_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TRIG_EDGE && !init_i && !ack_i && req_o) |=> req_o); // R3
  AST_ACK_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && mode_i == TRIG_EDGE && !init_i && ack_i && !(line_i && !$past(line_i)))
      |=> !req_o); // R4
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_latch_pkg::*;
#(
  parameter int unsigned          NUM_LINES = 8,
  parameter logic [NUM_LINES-1:0] WR_MASK   = '1,
  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic                 init_clr_i,
  input  logic                 trig_we_i,
  input  logic [NUM_LINES-1:0] trig_wdata_i,
  output logic [NUM_LINES-1:0] trig_rdata_o,
  input  logic                 ack_i,
  input  logic [IDX_W-1:0]     ack_line_i,
  output logic [NUM_LINES-1:0] req_o
);
  logic [NUM_LINES-1:0] mode_vec;
  logic [NUM_LINES-1:0] ack_vec;

  irq_trig_reg #(.NUM_LINES(NUM_LINES), .WR_MASK(WR_MASK)) u_trig (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (trig_we_i),
    .wdata_i (trig_wdata_i),
    .mode_o  (mode_vec)
  );

  irq_ack_decode #(.NUM_LINES(NUM_LINES)) u_ack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ack_i      (ack_i),
    .ack_line_i (ack_line_i),
    .ack_vec_o  (ack_vec)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    irq_line_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mode_i (trig_mode_e'(mode_vec[g])),
      .line_i (line_i[g]),
      .ack_i  (ack_vec[g]),
      .init_i (init_clr_i),
      .req_o  (req_o[g])
    );
  end

  assign trig_rdata_o = mode_vec;

  AST_INIT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_clr_i |=> (req_o == '0)); // R7
  AST_INIT_KEEP_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_clr_i && !trig_we_i) |=> $stable(trig_rdata_o)); // R7
endmodule

// File: tb/irq_req_latch_bench.sv
module irq_req_latch_bench;
  localparam int unsigned N    = 8;
  localparam logic [7:0]  MASK = 8'hF3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] line = '0;
  logic       init_clr = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ack = 1'b0;
  logic [2:0] ack_line = '0;
  logic [7:0] req;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_req_latch #(.NUM_LINES(N), .WR_MASK(MASK)) u_irq_req_latch (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .line_i       (line),
    .init_clr_i   (init_clr),
    .trig_we_i    (we),
    .trig_wdata_i (wdata),
    .trig_rdata_o (rdata),
    .ack_i        (ack),
    .ack_line_i   (ack_line),
    .req_o        (req)
  );

  typedef struct packed {
    logic [7:0] line;
    logic       we;
    logic [7:0] wdata;
    logic       ack;
    logic [2:0] ack_line;
    logic [7:0] exp_req;
    logic [7:0] exp_trig;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{8'h01, 1'b0, 8'h00, 1'b0, 3'd0, 8'h01, 8'h00}, // R2 rise latches
    '{8'h00, 1'b0, 8'h00, 1'b0, 3'd0, 8'h01, 8'h00}, // R3 fall keeps
    '{8'h00, 1'b0, 8'h00, 1'b1, 3'd0, 8'h00, 8'h00}, // R4 ack clears edge
    '{8'h81, 1'b0, 8'h00, 1'b0, 3'd0, 8'h81, 8'h00}, // R2
    '{8'h81, 1'b0, 8'h00, 1'b1, 3'd7, 8'h01, 8'h00}, // R3 held high no relatch
    '{8'h01, 1'b1, 8'hFF, 1'b0, 3'd0, 8'h01, 8'hF3}, // R5 masked write
    '{8'h0C, 1'b0, 8'h00, 1'b0, 3'd0, 8'h0C, 8'hF3}, // R1 level follows, edge bits set
    '{8'h1C, 1'b0, 8'h00, 1'b1, 3'd4, 8'h1C, 8'hF3}, // R4 ack on level ignored
    '{8'h00, 1'b0, 8'h00, 1'b1, 3'd2, 8'h08, 8'hF3}, // R1 level drops, R4 edge ack
    '{8'h08, 1'b0, 8'h00, 1'b1, 3'd3, 8'h08, 8'hF3}, // R4 rise beats ack
    '{8'h00, 1'b1, 8'h00, 1'b0, 3'd0, 8'h08, 8'h00}  // R5 clear trig, R3 hold
  };

  task automatic check(input string rq, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs;
    we = 1'b0; ack = 1'b0; init_clr = 1'b0;
  endtask

  initial begin
    #50;
    check("R6 reset req", req, 8'h00);
    check("R6 reset trig", rdata, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      line = VECS[i].line; we = VECS[i].we; wdata = VECS[i].wdata;
      ack = VECS[i].ack; ack_line = VECS[i].ack_line;
      step();
      check($sformatf("R1-R5 vec%0d req", i), req, VECS[i].exp_req);
      check($sformatf("R5 vec%0d trig", i), rdata, VECS[i].exp_trig);
      idle_inputs();
    end

    // R5: non-writable bits read back zero
    @(negedge clk);
    we = 1'b1; wdata = 8'h0C; line = 8'h00;
    step();
    check("R5 masked bits", rdata, 8'h00);
    idle_inputs();

    // R7: init clears req/history, keeps trig, relatches held edge input
    @(negedge clk);
    we = 1'b1; wdata = 8'h10; line = 8'h01;
    step();
    check("R7 setup req", req, 8'h09);
    idle_inputs();
    @(negedge clk);
    init_clr = 1'b1;
    step();
    check("R7 init req", req, 8'h00);
    check("R7 init trig", rdata, 8'h10);
    idle_inputs();
    @(negedge clk);
    step();
    check("R7 relatch", req, 8'h01);

    // R8: single-cycle pulse on edge line
    @(negedge clk);
    line = 8'h21;
    @(negedge clk);
    line = 8'h01;
    step();
    check("R8 pulse", req, 8'h21);

    // R6: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R6 async req", req, 8'h00);
    check("R6 async trig", rdata, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    line = 8'h00;
    step();
    check("R6 after reset", req, 8'h00);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule